// File: doc/BRIEF.md
# Multiplier Modulo 2^16+1

This unit multiplies two 16-bit operands in the ring of integers modulo 65537 (2^16+1). The code 0 stands for the value 65536, in both operands and in the result. So every 16-bit code maps to a nonzero residue, and every product is invertible. This kind of multiplier is the nonlinear step of some block ciphers.

The reduction uses no divider. Each operand is widened to 17 bits, and a zero code becomes 65536. The full product is then split into a low half and a high half. Because 2^16 is congruent to -1 modulo 65537, the residue is the low half minus the high half. When that difference is negative, adding the modulus gives the proper value. This correction changes only the lowest bit position, so it is a single carry-in of one.

The arithmetic is purely combinational. By default a register stage holds the result, so the answer appears one clock after the operands are sampled. A parameter removes that stage.

Top module: `modmul_pm1`

## Requirements
- R1: For operands whose values lie in 1..65535, the result equals the product of the two values reduced modulo 65537 and then taken modulo 65536.
- R2: An operand code of 0 is treated as the value 65536 in the product.
- R3: A residue of 65536 is emitted as the code 0, for example 256 times 256.
- R4: Both operands coded 0 (65536 times 65536) give the result 1.
- R5: An operand code of 1 is the identity: the result equals the other operand code.
- R6: When one operand code is 0, the result equals (1 minus the other code) modulo 65536.
- R7: With the output stage enabled (the default), the result for operands present at a rising clock edge appears on the output after that edge and holds until the next edge.
- R8: A synchronous active-high reset drives the registered result to 0 at the next rising edge.
- R9: Swapping the two operands does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opa | input | 16 | First operand code (0 means 65536) |
| opb | input | 16 | Second operand code (0 means 65536) |
| res | output | 16 | Product modulo 65537 (65536 emitted as 0) |

## Verification
The hardest case to reach from the ports is the one where the difference goes negative and the correction lands exactly on 65536, so that the result must wrap to code 0. Random operands almost never produce it. The stimulus therefore uses pairs whose true product is a power-of-two multiple of 65536, such as 256 times 256 and 32768 times 2. It also uses pairs with a zero-coded operand, where the high half is large. Both kinds sit in the vector table next to the double-zero case, which has the largest possible high half.

// File: rtl/mm_pkg.sv
package mm_pkg;
  // Default operand width; the modulus is 2**MM_W + 1.
  parameter int unsigned MM_W = 16;

  // Result stage selection.
  typedef enum logic [0:0] {
    STAGE_COMB = 1'b0,
    STAGE_REG  = 1'b1
  } stage_e;
endpackage

// File: rtl/mm_expand.sv
module mm_expand #(
  parameter int unsigned W = mm_pkg::MM_W
) (
  input  logic [W-1:0] code_i,
  output logic [W:0]   val_o
);
  // The all-zero code denotes 2**W.
  always_comb begin
    if (code_i == '0) val_o = {1'b1, {W{1'b0}}};
    else              val_o = {1'b0, code_i};
  end
endmodule

// File: rtl/mm_mult.sv
module mm_mult #(
  parameter int unsigned W  = mm_pkg::MM_W,
  localparam int unsigned PW = 2*W + 2
) (
  input  logic [W:0]    x_i,
  input  logic [W:0]    y_i,
  output logic [PW-1:0] p_o
);
  always_comb p_o = PW'(x_i) * PW'(y_i);
endmodule

// File: rtl/mm_reduce.sv
module mm_reduce #(
  parameter int unsigned W  = mm_pkg::MM_W,
  localparam int unsigned PW = 2*W + 2,
  localparam int unsigned DW = W + 2
) (
  input  logic [PW-1:0] p_i,
  output logic [W-1:0]  r_o
);
  logic [W-1:0]  lo;
  logic [DW-1:0] hi;
  logic [DW-1:0] diff;
  logic          neg;

  // 2**W == -1 (mod 2**W+1): residue = lo - hi, plus the modulus if negative.
  // Adding 2**W+1 only alters the low W bits by one, so the fix is a +1.
  always_comb begin
    lo   = p_i[W-1:0];
    hi   = p_i[PW-1:W];
    diff = DW'(lo) - hi;
    neg  = diff[DW-1];
    r_o  = diff[W-1:0] + W'(neg);
  end
endmodule

// File: rtl/modmul_pm1.sv
module modmul_pm1 #(
  parameter int unsigned    W       = mm_pkg::MM_W,
  parameter mm_pkg::stage_e OUT_REG = mm_pkg::STAGE_REG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  localparam int unsigned PW = 2*W + 2;

  logic [W:0]    va, vb;
  logic [PW-1:0] prod;
  logic [W-1:0]  red;

  mm_expand #(.W(W)) u_exp_a (.code_i(opa), .val_o(va));
  mm_expand #(.W(W)) u_exp_b (.code_i(opb), .val_o(vb));
  mm_mult   #(.W(W)) u_mul   (.x_i(va), .y_i(vb), .p_o(prod));
  mm_reduce #(.W(W)) u_red   (.p_i(prod), .r_o(red));

  generate
    if (OUT_REG == mm_pkg::STAGE_REG) begin : g_reg
      logic [W-1:0] res_q;
      always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= red;
      end
      assign res = res_q;
    end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign res = red;
    end
  endgenerate
endmodule

// File: rtl/modmul_pm1_chk.sv
module modmul_pm1_chk #(
  parameter int unsigned    W       = mm_pkg::MM_W,
  parameter mm_pkg::stage_e OUT_REG = mm_pkg::STAGE_REG
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] res
);
  generate
    if (OUT_REG == mm_pkg::STAGE_REG) begin : g_reg
      AST_IDENTITY_A: assert property (@(posedge clk) disable iff (rst)
        (opa == W'(1)) |=> (res == $past(opb)));                          // R5
      AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (opa == '0) |=> (res == W'(W'(1) - $past(opb))));                 // R6
      AST_DOUBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (opa == '0 && opb == '0) |=> (res == W'(1)));                     // R4
      AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (res == '0));                                             // R8
      AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($stable(opa) && $stable(opb) && !$past(rst)) |=> $stable(res));  // R7
    end else begin : g_comb
      AST_IDENTITY_A: assert property (@(posedge clk)
        (opa == W'(1)) |-> (res == opb));                                 // R5
      AST_ZERO_OPERAND: assert property (@(posedge clk)
        (opa == '0) |-> (res == W'(W'(1) - opb)));                        // R6
      AST_DOUBLE_ZERO: assert property (@(posedge clk)
        (opa == '0 && opb == '0) |-> (res == W'(1)));                     // R4
      AST_IDENTITY_B: assert property (@(posedge clk)
        (opb == W'(1)) |-> (res == opa));                                 // R5
    end
  endgenerate
endmodule

bind modmul_pm1 modmul_pm1_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .opa(opa), .opb(opb), .res(res)
);

// File: tb/modmul_pm1_tb.sv
module modmul_pm1_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  localparam int NRAND = 300;

  // {opa, opb, expected}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h0001, 16'h0001, 16'h0001},  // R1 R5
    {16'h0002, 16'h0003, 16'h0006},  // R1
    {16'h0000, 16'h0000, 16'h0001},  // R4
    {16'h0000, 16'h0001, 16'h0000},  // R2 R3 R6
    {16'h0000, 16'h0002, 16'hFFFF},  // R2 R6
    {16'hFFFF, 16'hFFFF, 16'h0004},  // R1
    {16'h8000, 16'h0002, 16'h0000},  // R3
    {16'h0100, 16'h0100, 16'h0000},  // R3
    {16'h0100, 16'h0200, 16'hFFFF},  // R1
    {16'h8000, 16'h8000, 16'hC001},  // R1
    {16'hFFFF, 16'h0002, 16'hFFFD},  // R1
    {16'h0000, 16'hFFFF, 16'h0002},  // R2 R6
    {16'h1234, 16'h0001, 16'h1234},  // R5
    {16'h0001, 16'hABCD, 16'hABCD}   // R5
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic [15:0] res;

  int checks = 0;
  int fails  = 0;

  modmul_pm1 u_dut (.clk(clk), .rst(rst), .opa(opa), .opb(opb), .res(res));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_mul(input logic [15:0] x, input logic [15:0] y);
    longint unsigned xv, yv;
    xv = (x == 16'h0) ? 64'd65536 : 64'(x);
    yv = (y == 16'h0) ? 64'd65536 : 64'(y);
    return 16'(((xv * yv) % 64'd65537) % 64'd65536);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, the register captures at posedge, sample at the next negedge (R7).
  task automatic apply(input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    opa = x;
    opb = y;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] x, y, r1;
    opa = 16'h1234;
    opb = 16'h5678;
    repeat (3) @(negedge clk);
    check("R8 reset state", res, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][47:32], VEC[i][31:16]);
      check("R1-table vector", res, VEC[i][15:0]);
    end

    // R7: latency and hold
    @(negedge clk);
    opa = 16'h0003;
    opb = 16'h0005;
    check("R7 old result before edge", res, VEC[NVEC-1][15:0]);
    @(negedge clk);
    check("R7 new result after edge", res, 16'h000F);
    @(negedge clk);
    check("R7 hold with stable inputs", res, 16'h000F);

    // R8: reset mid-run with nonzero inputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 synchronous clear", res, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R8 resume after reset", res, 16'h000F);

    // R2 R6: zero operand sweep
    for (int k = 0; k < 16; k++) begin
      y = 16'(k * 4099 + 1);
      apply(16'h0000, y);
      check("R6 zero operand", res, 16'(17'd65537 - 17'(y)));
    end

    // R1 R9: random operands and swapped order
    for (int k = 0; k < NRAND; k++) begin
      x = 16'($urandom);
      y = 16'($urandom);
      if (k % 17 == 0) x = 16'h0;
      if (k % 23 == 0) y = 16'hFFFF;
      apply(x, y);
      r1 = res;
      check("R1 random product", r1, ref_mul(x, y));
      apply(y, x);
      check("R9 swapped operands", res, r1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule